// File: doc/BRIEF.md
# IrDA SIR Pulse Encoder/Decoder

This block sits between the serial output and input of a UART core and an infrared transceiver. On the transmit side it turns NRZ bits into return-to-zero infrared pulses: every zero bit gives one short high pulse at the start of its bit period, and every one bit leaves the line low. The pulse width can be set two ways. It can be three ticks of the 16x baud clock, which is 3/16 of a bit. It can also be a fixed number of peripheral clock cycles, chosen by a 3-bit divider. On the receive side it synchronises the pin, can invert it, and stretches each detected pulse back into a zero bit that lasts a full bit period.

The block has a control word whose fields are captured into shadow registers. The capture happens only while both the encoder and the decoder are idle, so a change in the middle of a frame does not disturb it. When the enable field is clear the block is transparent: the UART transmit bit goes straight to the infrared pin and the pin goes straight to the UART receive input.

Encoder states: `TX_IDLE` (line low, waiting for a zero bit), `TX_PULSE` (output high), `TX_GAP` (rest of a zero bit, output low) and `TX_MARK` (a one bit, output low). The encoder moves from `TX_IDLE` to `TX_PULSE` on a baud tick that sees a zero. It moves from `TX_PULSE` to `TX_GAP` when the pulse width is reached. At each bit boundary it goes from any active state to `TX_PULSE` if the bit is zero, or to `TX_MARK` if the bit is one. It goes from `TX_MARK` back to `TX_IDLE` after `IDLE_BITS` one bits in a row.

Decoder states: `RX_IDLE`, `RX_SPACE` (recovered bit is zero) and `RX_MARK` (one bits inside a frame). A rising pulse edge in any state leads to `RX_SPACE`. The decoder moves from `RX_SPACE` to `RX_MARK` after 16 ticks with no new edge, and from `RX_MARK` to `RX_IDLE` after `IDLE_BITS` bit periods with no pulse.

Top module: `irda_sir_codec`

## Requirements
- R1: Control word fields are: bit 0 is the infrared enable, bit 1 is receive inversion, bit 2 is fixed-width enable, and bits 5:3 are the divider n. Bits 31:6 have no effect. All shadow fields are 0 after reset.
- R2: With the enable clear, `ir_tx` equals `tx_nrz` and `rx_nrz` equals `ir_rx` in the same cycle. The inversion bit has no effect in this mode.
- R3: With the enable set, `ir_tx` idles low. A zero bit that `tx_nrz` presents at a 16x tick produces a pulse starting the clock after that tick. Exactly one pulse is sent per zero bit, and none for a one bit. Bit boundaries occur every 16 ticks after the first zero.
- R4: With fixed-width enable clear, a pulse lasts 3 tick periods. The divider field then has no effect.
- R5: With fixed-width enable set, a pulse lasts 2^(n+1) clock cycles (n = 0 gives 2, n = 1 gives 4, up to n = 7 giving 256).
- R6: The inversion bit inverts only the received line. With it set, an idle-high pin gives a one, and a low pulse gives a zero. The transmitted pulses are unchanged.
- R7: With the enable set, a rising edge of the (optionally inverted) received line drives `rx_nrz` low from the third clock edge after the pin changes. It stays low for 16 ticks counted from the detected edge and then returns high.
- R8: A new pulse edge while `rx_nrz` is low restarts the 16-tick count.
- R9: The control word is copied into the shadow registers only while both encoder and decoder are idle. A change during a frame takes effect only after `IDLE_BITS` pulse-free bit periods.
- R10: During reset the shadow enable is 0, so the block is transparent whatever the control word input holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick16 | input | 1 | One-cycle strobe at 16x the baud rate |
| ctrl_word | input | 32 | Control word (fields in R1) |
| tx_nrz | input | 1 | Serial bit from the UART transmitter |
| ir_tx | output | 1 | Drive to the infrared emitter |
| ir_rx | input | 1 | Line from the infrared detector |
| rx_nrz | output | 1 | Recovered serial bit to the UART receiver |

## Verification
The assertions check on every cycle that:
- a transmit pulse only starts after a sampled zero bit;
- a pulse in baud-tick mode never spans more than three ticks;
- the enabled output is low whenever the encoder is idle;
- the shadow configuration never changes after a busy cycle;
- a detected edge always produces a zero;
- a recovered zero never outlasts 16 ticks from its most recent edge.

Only the bench scenarios can show the exact pulse widths for each divider, the pulse count per byte pattern, that the reserved bits and the inversion have no effect on transmit, the transparent mode, and that a mid-frame control change is deferred until the line goes quiet.

// File: rtl/irda_sir_pkg.sv
package irda_sir_pkg;

    localparam int PDIV_W        = 3;
    localparam int CFG_W         = PDIV_W + 3;
    localparam int TICKS_PER_BIT = 16;
    localparam int PULSE_TICKS   = 3;
    localparam int PH_W          = $clog2(TICKS_PER_BIT);
    localparam int WCNT_W        = (1 << PDIV_W) + 1;

    typedef struct packed {
        logic [PDIV_W-1:0] pdiv;
        logic              fix_en;
        logic              rx_inv;
        logic              ir_en;
    } irda_cfg_t;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_PULSE = 2'd1,
        TX_GAP   = 2'd2,
        TX_MARK  = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SPACE = 2'd1,
        RX_MARK  = 2'd2
    } rx_state_e;

endpackage

// File: rtl/irda_ctrl_shadow.sv
module irda_ctrl_shadow
    import irda_sir_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] ctrl_i,
    input  logic             idle_i,
    output irda_cfg_t        cfg_o
);

    irda_cfg_t cfg_q;

    // Capture only between frames so no field changes under a running bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (idle_i) begin
            cfg_q <= irda_cfg_t'(ctrl_i);
        end
    end

    assign cfg_o = cfg_q;

    // R9: configuration frozen while either direction is busy
    p_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(idle_i) |-> cfg_q == $past(cfg_q));

endmodule

// File: rtl/irda_sync.sv
module irda_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '0;
                else        sr <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = sr[STAGES-1];

endmodule

// File: rtl/irda_sir_encoder.sv
module irda_sir_encoder
    import irda_sir_pkg::*;
#(
    parameter int IDLE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              fix_i,
    input  logic [PDIV_W-1:0] pdiv_i,
    input  logic              tick_i,
    input  logic              tx_bit_i,
    output logic              pulse_o,
    output logic              idle_o
);

    localparam int ONES_W = $clog2(IDLE_BITS + 1);
    localparam logic [PH_W-1:0]   PH_LAST    = PH_W'(TICKS_PER_BIT - 1);
    localparam logic [PH_W-1:0]   PH_PULSE   = PH_W'(PULSE_TICKS - 1);
    localparam logic [ONES_W-1:0] ONES_LAST  = ONES_W'(IDLE_BITS - 1);

    tx_state_e           state, nxt;
    logic [PH_W-1:0]     phase;
    logic [WCNT_W-1:0]   wcnt;
    logic [WCNT_W-1:0]   w_last;
    logic [ONES_W-1:0]   ones;
    logic                boundary;
    logic                pulse_done;

    // 2 << n clocks, minus one for the terminal count
    assign w_last     = (WCNT_W'(2) << pdiv_i) - WCNT_W'(1);
    assign boundary   = tick_i && (phase == PH_LAST) && (state != TX_IDLE);
    assign pulse_done = fix_i ? (wcnt == w_last)
                              : (tick_i && (phase == PH_PULSE));

    always_comb begin
        nxt = state;
        if (!en_i) begin
            nxt = TX_IDLE;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    if (tick_i && !tx_bit_i) nxt = TX_PULSE;
                end
                TX_PULSE: begin
                    if (boundary)        nxt = tx_bit_i ? TX_MARK : TX_PULSE;
                    else if (pulse_done) nxt = TX_GAP;
                end
                TX_GAP: begin
                    if (boundary) nxt = tx_bit_i ? TX_MARK : TX_PULSE;
                end
                TX_MARK: begin
                    if (boundary) begin
                        if (!tx_bit_i)             nxt = TX_PULSE;
                        else if (ones == ONES_LAST) nxt = TX_IDLE;
                        else                        nxt = TX_MARK;
                    end
                end
                default: nxt = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
            wcnt  <= '0;
            ones  <= '0;
        end else begin
            if (nxt != TX_IDLE && (state == TX_IDLE || boundary))
                phase <= '0;
            else if (tick_i && state != TX_IDLE)
                phase <= phase + 1'b1;

            if (nxt == TX_PULSE && (state != TX_PULSE || boundary))
                wcnt <= '0;
            else if (state == TX_PULSE)
                wcnt <= wcnt + 1'b1;

            if (state == TX_IDLE)
                ones <= '0;
            else if (boundary)
                ones <= tx_bit_i ? ones + 1'b1 : '0;
        end
    end

    always_comb begin
        pulse_o = (state == TX_PULSE);
        idle_o  = (state == TX_IDLE);
    end

    // checker state: ticks seen while the pulse is high
    logic [2:0] a_hi_ticks;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          a_hi_ticks <= '0;
        else if (!pulse_o)                   a_hi_ticks <= '0;
        else if (tick_i && a_hi_ticks != 3'd7) a_hi_ticks <= a_hi_ticks + 1'b1;
    end

    // R3: a pulse only begins after a zero bit was sampled
    p_pulse_on_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && $past(en_i) && $rose(pulse_o) |-> !$past(tx_bit_i));

    // R4: baud-tick mode pulse never spans more than three ticks
    p_tick_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && !fix_i |-> a_hi_ticks <= 3'd3);

endmodule

// File: rtl/irda_sir_decoder.sv
module irda_sir_decoder
    import irda_sir_pkg::*;
#(
    parameter int IDLE_BITS   = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic inv_i,
    input  logic tick_i,
    input  logic rx_pin_i,
    output logic rx_bit_o,
    output logic idle_o
);

    localparam int ONES_W = $clog2(IDLE_BITS + 1);
    localparam logic [PH_W-1:0]   CNT_LAST  = PH_W'(TICKS_PER_BIT - 1);
    localparam logic [ONES_W-1:0] ONES_LAST = ONES_W'(IDLE_BITS - 1);

    rx_state_e         state, nxt;
    logic              pin_s;
    logic              level;
    logic              level_d;
    logic              rise;
    logic              bit_end;
    logic [PH_W-1:0]   cnt;
    logic [ONES_W-1:0] ones;

    irda_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_pin_i),
        .q_o   (pin_s)
    );

    assign level = pin_s ^ inv_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    assign rise    = level && !level_d;
    assign bit_end = tick_i && (cnt == CNT_LAST) && (state != RX_IDLE);

    always_comb begin
        nxt = state;
        if (!en_i) begin
            nxt = RX_IDLE;
        end else if (rise) begin
            nxt = RX_SPACE;
        end else begin
            unique case (state)
                RX_IDLE:  nxt = RX_IDLE;
                RX_SPACE: if (bit_end) nxt = RX_MARK;
                RX_MARK:  if (bit_end) nxt = (ones == ONES_LAST) ? RX_IDLE : RX_MARK;
                default:  nxt = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            ones <= '0;
        end else begin
            if (rise)
                cnt <= '0;
            else if (tick_i && state != RX_IDLE)
                cnt <= cnt + 1'b1;

            if (rise || state == RX_IDLE)
                ones <= '0;
            else if (bit_end && state == RX_MARK)
                ones <= ones + 1'b1;
        end
    end

    always_comb begin
        rx_bit_o = (state != RX_SPACE);
        idle_o   = (state == RX_IDLE);
    end

    // checker state: ticks since the most recent detected edge
    logic [4:0] a_ticks;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        a_ticks <= '0;
        else if (rise)                     a_ticks <= '0;
        else if (tick_i && a_ticks != 5'd31) a_ticks <= a_ticks + 1'b1;
    end

    // R7: every detected edge yields a recovered zero next cycle
    p_rise_gives_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && rise |=> !rx_bit_o);

    // R8: a zero never outlasts 16 ticks from its latest edge
    p_space_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && !rx_bit_o |-> a_ticks <= 5'd15);

endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec
    import irda_sir_pkg::*;
#(
    parameter int CTRL_W      = 32,
    parameter int IDLE_BITS   = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick16,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              tx_nrz,
    output logic              ir_tx,
    input  logic              ir_rx,
    output logic              rx_nrz
);

    irda_cfg_t cfg;
    logic      enc_pulse;
    logic      enc_idle;
    logic      dec_bit;
    logic      dec_idle;
    logic      unused_rsvd;

    assign unused_rsvd = ^ctrl_word[CTRL_W-1:CFG_W];

    irda_ctrl_shadow u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl_i (ctrl_word[CFG_W-1:0]),
        .idle_i (enc_idle && dec_idle),
        .cfg_o  (cfg)
    );

    irda_sir_encoder #(.IDLE_BITS(IDLE_BITS)) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (cfg.ir_en),
        .fix_i    (cfg.fix_en),
        .pdiv_i   (cfg.pdiv),
        .tick_i   (baud_tick16),
        .tx_bit_i (tx_nrz),
        .pulse_o  (enc_pulse),
        .idle_o   (enc_idle)
    );

    irda_sir_decoder #(
        .IDLE_BITS   (IDLE_BITS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (cfg.ir_en),
        .inv_i    (cfg.rx_inv),
        .tick_i   (baud_tick16),
        .rx_pin_i (ir_rx),
        .rx_bit_o (dec_bit),
        .idle_o   (dec_idle)
    );

    assign ir_tx  = cfg.ir_en ? enc_pulse : tx_nrz;
    assign rx_nrz = cfg.ir_en ? dec_bit   : ir_rx;

    // R3: emitter dark whenever the encoder rests
    p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.ir_en && enc_idle |-> !ir_tx);

endmodule

// File: tb/irda_sir_codec_tb.sv
module irda_sir_codec_tb;

    localparam int TDIV  = 4;
    localparam int IDLEB = 12;
    localparam int NVEC  = 8;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [7:0]  data;
        logic [15:0] w;
        logic [15:0] n;
    } vec_t;

    // ctrl: bit0 enable, bit1 rx invert, bit2 fixed, bits5:3 divider
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0001, 8'h55, 16'(3*TDIV), 16'd5},
        '{32'h0000_0029, 8'h00, 16'(3*TDIV), 16'd9},
        '{32'h0000_0005, 8'hFF, 16'd2,       16'd1},
        '{32'h0000_000D, 8'h0F, 16'd4,       16'd5},
        '{32'h0000_0017, 8'hA5, 16'd8,       16'd5},
        '{32'h0000_001D, 8'h3C, 16'd16,      16'd5},
        '{32'hFFFF_FFC5, 8'h81, 16'd2,       16'd7},
        '{32'h0000_0003, 8'h01, 16'(3*TDIV), 16'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        baud_tick16;
    logic [31:0] ctrl_word = 32'h1;
    logic        tx_nrz = 1'b1;
    logic        ir_tx;
    logic        ir_rx = 1'b0;
    logic        rx_nrz;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int tdiv_cnt = 0;
    int hi_run = 0, npulse = 0, min_w = 9999, max_w = 0;
    int lo_run = 0, last_lo = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) tdiv_cnt <= 0;
        else        tdiv_cnt <= (tdiv_cnt == TDIV-1) ? 0 : tdiv_cnt + 1;
    end
    assign baud_tick16 = (tdiv_cnt == TDIV-1);

    irda_sir_codec #(.IDLE_BITS(IDLEB)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud_tick16 (baud_tick16),
        .ctrl_word   (ctrl_word),
        .tx_nrz      (tx_nrz),
        .ir_tx       (ir_tx),
        .ir_rx       (ir_rx),
        .rx_nrz      (rx_nrz)
    );

    always @(posedge clk) begin
        if (ir_tx) hi_run++;
        else if (hi_run != 0) begin
            npulse++;
            if (hi_run < min_w) min_w = hi_run;
            if (hi_run > max_w) max_w = hi_run;
            hi_run = 0;
        end
        if (!rx_nrz) lo_run++;
        else if (lo_run != 0) begin
            last_lo = lo_run;
            lo_run = 0;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic next_tick();
        @(negedge clk);
        while (!baud_tick16) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        next_tick();
        tx_nrz = b;
        repeat (15) next_tick();
    endtask

    task automatic send_frame(input logic [7:0] d);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        send_bit(1'b1);
    endtask

    task automatic quiet_bits(input int n);
        repeat (n * 16) next_tick();
    endtask

    task automatic clear_stats();
        npulse = 0; min_w = 9999; max_w = 0;
    endtask

    task automatic rx_pulse(input logic active);
        ir_rx = active;
        repeat (3) @(negedge clk);
        ir_rx = ~active;
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                if (!done) begin
                    errors++;
                    $display("FAIL watchdog: actual timeout expected completion");
                    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                    $finish;
                end
            end
        join_none
    end

    initial begin
        // R10 / R1: shadow clear in reset, so transparent despite enable on input
        repeat (3) @(negedge clk);
        check("R10 ir_tx passthrough in reset", ir_tx, 1);
        check("R10 rx_nrz passthrough low", rx_nrz, 0);
        ir_rx = 1'b1; #1;
        check("R10 rx_nrz passthrough high", rx_nrz, 1);
        ir_rx = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R3 R9 enabled idle line low", ir_tx, 0);

        // table walk: R3 pulse counts, R4/R5 widths, R1 reserved bits, R6 tx unaffected
        for (int i = 0; i < NVEC; i++) begin
            ctrl_word = VECS[i].ctrl;
            repeat (4) @(negedge clk);
            clear_stats();
            send_frame(VECS[i].data);
            quiet_bits(IDLEB + 4);
            check("R3 pulse count", npulse, int'(VECS[i].n));
            if (VECS[i].ctrl[2]) begin
                check("R5 min width", min_w, int'(VECS[i].w));
                check("R5 max width", max_w, int'(VECS[i].w));
            end else begin
                check("R4 min width", min_w, int'(VECS[i].w));
                check("R4 max width", max_w, int'(VECS[i].w));
            end
            if (VECS[i].ctrl[1])
                check("R6 tx width with invert", max_w, int'(VECS[i].w));
            if (VECS[i].ctrl[31])
                check("R1 reserved bits ignored", max_w, int'(VECS[i].w));
        end

        // R9: control change mid-frame is deferred
        ctrl_word = 32'h0000_000D;
        repeat (4) @(negedge clk);
        clear_stats();
        send_bit(1'b0);
        send_bit(1'b0);
        ctrl_word = 32'h0000_0015;
        for (int i = 0; i < 7; i++) send_bit(1'b0);
        send_bit(1'b1);
        quiet_bits(IDLEB + 4);
        check("R9 mid-frame pulses", npulse, 9);
        check("R9 old width kept min", min_w, 4);
        check("R9 old width kept max", max_w, 4);
        clear_stats();
        send_frame(8'hFE);
        quiet_bits(IDLEB + 4);
        check("R9 new width after idle", max_w, 8);
        check("R9 new width count", npulse, 2);
        check("R9 new width min", min_w, 8);

        // R2: disabled, inversion bit set but ignored
        ctrl_word = 32'h0000_0002;
        repeat (4) @(negedge clk);
        tx_nrz = 1'b0; #1;
        check("R2 tx pass low", ir_tx, 0);
        tx_nrz = 1'b1; #1;
        check("R2 tx pass high", ir_tx, 1);
        ir_rx = 1'b1; #1;
        check("R2 rx pass high no invert", rx_nrz, 1);
        ir_rx = 1'b0; #1;
        check("R2 rx pass low no invert", rx_nrz, 0);

        // R7: receive latency and stretch
        ctrl_word = 32'h0000_0001;
        repeat (4) @(negedge clk);
        check("R7 rx idle high", rx_nrz, 1);
        ir_rx = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7 rx still high after two edges", rx_nrz, 1);
        @(negedge clk);
        check("R7 rx low after third edge", rx_nrz, 0);
        ir_rx = 1'b0;
        repeat (120) @(negedge clk);
        check_rng("R7 zero length", last_lo, 60, 65);
        check("R7 rx back high", rx_nrz, 1);

        // R8: second pulse restarts the stretch
        rx_pulse(1'b1);
        repeat (37) @(negedge clk);
        rx_pulse(1'b1);
        repeat (150) @(negedge clk);
        check_rng("R8 resync zero length", last_lo, 99, 106);

        // R6: inverted receive, idle-high line
        quiet_bits(IDLEB + 4);
        ctrl_word = 32'h0000_0000;
        repeat (4) @(negedge clk);
        ir_rx = 1'b1;
        repeat (4) @(negedge clk);
        ctrl_word = 32'h0000_0003;
        repeat (50) @(negedge clk);
        check("R6 idle-high line reads one", rx_nrz, 1);
        rx_pulse(1'b0);
        check("R6 low pulse gives zero", rx_nrz, 0);
        repeat (120) @(negedge clk);
        check("R6 recovers to one", rx_nrz, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule